// File: doc/BRIEF.md
# Two-Source Bootstrap Program Loader

This block fills an on-chip program RAM with its first image straight after reset, before any processor fetches from it. It first makes a single probe read of the external byte-wide memory at a fixed base address. A dedicated data line returns bit 23 of that location, and that bit picks where the image comes from. When the bit is set, the loader walks the external memory upward from the base, one byte per read. Each read holds the address steady for a parameterised number of wait cycles. Every three bytes are packed into one 24-bit word, with the lowest address becoming the least significant byte.

When the bit is clear, the image arrives from a host port instead. The host port has three byte lanes. A write to the low lane closes a word that is made of the latest high and mid lane values plus the low byte. In this mode the host may cut the load short by raising an exit flag. Either way, words land on consecutive RAM addresses starting at zero. A single-cycle completion pulse then releases the processor to start at address zero. After that the loader stays silent until the next reset.

Top module: `boot_loader`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy` is 1, `done` is 0, `ram_we` is 0, `src_ext` is 0, and a probe read is under way (`ext_rd` 1, `ext_addr` equal to the base address).
- R2: The value of `ext_flag` captured by the probe read decides the source. A 1 selects the external memory and sets `src_ext`. A 0 selects the host port; `src_ext` stays 0 and no further external read is issued.
- R3: On the external path, RAM word n is {byte at base+3n+2, byte at base+3n+1, byte at base+3n}. Each byte is taken from `ext_data[7:0]`, so the probe location is read again as the low byte of word 0.
- R4: Each external read holds `ext_rd` high with a stable `ext_addr` for WAIT_CYC+1 cycles and captures the byte on the last of them. A full external load therefore keeps `ext_rd` high for (3*WORDS+1)*(WAIT_CYC+1) cycles, and `done` is high in cycle (3*WORDS+1)*(WAIT_CYC+1)+1 after reset release.
- R5: Each finished word produces exactly one RAM write. Writes go to addresses 0, 1, 2 and so on up to WORDS-1, one cycle after the word completes.
- R6: Host lane codes on `host_sel` are 2 for the high byte, 1 for the mid byte and 0 for the low byte. A low-lane write completes the word {high, mid, low}, and the high and mid lanes may be written in either order. Code 3 has no effect.
- R7: In host mode, a high `host_exit` ends the load, and `done` is high in the following cycle. A low-lane write in the same cycle as the exit is discarded.
- R8: `done` is a one-cycle pulse that follows the final RAM write by one cycle. `busy` is low from then on.
- R9: After `done`, no RAM write and no external read occurs, and host writes are ignored until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_rd | output | 1 | External read strobe, held high during each read |
| ext_addr | output | 16 | External byte address |
| ext_data | input | 8 | External read data byte |
| ext_flag | input | 1 | External data line carrying bit 23 of the addressed word |
| host_wr | input | 1 | Host byte write strobe |
| host_sel | input | 2 | Host lane select: 2 high, 1 mid, 0 low, 3 unused |
| host_data | input | 8 | Host write byte |
| host_exit | input | 1 | Host early-exit flag, active high |
| ram_we | output | 1 | Program RAM write enable |
| ram_addr | output | 9 | Program RAM word address |
| ram_wdata | output | 24 | Program RAM write data |
| busy | output | 1 | Load in progress |
| src_ext | output | 1 | External source selected |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the loader with WORDS=16 and WAIT_CYC=2, which keeps every word of a full image small enough to check individually. Under this setting a complete external load takes 148 cycles, so the exact cycle count of the wait-state timing can be checked against the closed-form formula. The same setting lets the host path be run to the last word, and also to an early exit after five words. That brings the full-image completion and the exit-versus-low-write collision within reach, along with the post-completion silence.

// File: rtl/boot_pkg.sv
// Shared types for the bootstrap loader.
// Assumes 24-bit program words assembled from 8-bit bytes.
package boot_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 24;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Host byte lane codes
    localparam logic [1:0] LANE_LOW  = 2'd0;
    localparam logic [1:0] LANE_MID  = 2'd1;
    localparam logic [1:0] LANE_HIGH = 2'd2;

    typedef enum logic [2:0] {
        ST_PROBE,
        ST_EXT,
        ST_HOST,
        ST_FIN,
        ST_HALT
    } boot_state_t;
endpackage

// File: rtl/boot_ext_reader.sv
// Sequential byte reader for the external memory with fixed wait states.
// Each read holds the address for WAIT_CYC+1 cycles and captures on the last.
// It packs three bytes per word, low byte first. A clear rewinds it to the base address.
// Assumes ext_data/ext_flag are valid while ext_rd is held.
module boot_ext_reader
    import boot_pkg::*;
#(
    parameter int          EXT_AW   = 16,
    parameter int unsigned BASE     = 32'hC000,
    parameter int          WAIT_CYC = 2,
    parameter int          WORDS    = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    output logic              ext_rd,
    output logic [EXT_AW-1:0] ext_addr,
    input  byte_t             ext_data,
    input  logic              ext_flag,
    output logic              byte_vld,
    output logic              flag_bit,
    output logic              word_vld,
    output word_t             word
);
    localparam int CW    = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;
    localparam int BYTES = 3 * WORDS;
    localparam int OW    = $clog2(BYTES + 1);

    logic [CW-1:0] wait_q;
    logic [OW-1:0] off_q;
    logic [1:0]    lane_q;
    byte_t         low_q, mid_q;
    logic          cap;

    assign cap = en && (wait_q == CW'(WAIT_CYC));

    // Wait counter, byte offset, lane position and held bytes
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wait_q <= '0;
            off_q  <= '0;
            lane_q <= 2'd0;
            low_q  <= '0;
            mid_q  <= '0;
        end else if (en) begin
            if (cap) begin
                wait_q <= '0;
                off_q  <= off_q + 1'b1;
                lane_q <= (lane_q == 2'd2) ? 2'd0 : lane_q + 2'd1;
                if (lane_q == 2'd0) low_q <= ext_data;
                if (lane_q == 2'd1) mid_q <= ext_data;
            end else begin
                wait_q <= wait_q + 1'b1;
            end
        end
    end

    // Bus outputs and assembled word
    always_comb begin
        ext_rd   = en;
        ext_addr = EXT_AW'(BASE) + EXT_AW'(off_q);
        byte_vld = cap;
        flag_bit = ext_flag;
        word_vld = cap && (lane_q == 2'd2);
        word     = {ext_data, mid_q, low_q};
    end

    // R4: address stays put until the byte is captured
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cap && !clr) |=> $stable(ext_addr));
    // R3: a completed word always follows two earlier captures of the same group
    a_r3_lane_range: assert property (@(posedge clk) disable iff (!rst_n)
        lane_q != 2'd3);
endmodule

// File: rtl/boot_host_packer.sv
// Host byte-lane register set. High and mid lanes are held.
// A write to the low lane presents a complete word for one cycle.
// Assumes the caller gates acceptance by mode.
module boot_host_packer
    import boot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] sel,
    input  byte_t      data,
    output logic       word_vld,
    output word_t      word
);
    byte_t hi_q, mid_q;

    // Capture the high and mid lane bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            mid_q <= '0;
        end else if (wr) begin
            if (sel == LANE_HIGH) hi_q  <= data;
            if (sel == LANE_MID)  mid_q <= data;
        end
    end

    // Low-lane write completes the word
    always_comb begin
        word_vld = wr && (sel == LANE_LOW);
        word     = {hi_q, mid_q, data};
    end

    // R6: the unused lane code leaves the held bytes untouched
    a_r6_lane3_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == 2'd3) |=> ($stable(hi_q) && $stable(mid_q)));
endmodule

// File: rtl/boot_ram_writer.sv
// Registered RAM write port with a word counter from zero.
// It flags full once WORDS words have been written and refuses further words.
// Assumes acc is a single-cycle offer per word.
module boot_ram_writer
    import boot_pkg::*;
#(
    parameter int WORDS = 512,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  word_t         word,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output word_t         ram_wdata,
    output logic          full
);
    logic [AW-1:0] cnt_q;

    // Issue one registered write per accepted word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            full      <= 1'b0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= 1'b0;
            if (acc && !full) begin
                ram_we    <= 1'b1;
                ram_addr  <= cnt_q;
                ram_wdata <= word;
                cnt_q     <= cnt_q + 1'b1;
                if (cnt_q == AW'(WORDS - 1)) full <= 1'b1;
            end
        end
    end

    // R5: back-to-back writes move to the next address
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (!ram_we || ram_addr == $past(ram_addr) + 1'b1));
    // R9: once full, no write starts
    a_r9_full_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (full && ram_we) |=> !ram_we);
endmodule

// File: rtl/boot_loader.sv
// Bootstrap loader top. It probes the base location to pick the source, then runs
// the external reader or the host packer into the RAM writer. It ends with a
// one-cycle done pulse and stays idle until reset.
// Assumes the program RAM accepts one write per cycle.
module boot_loader
    import boot_pkg::*;
#(
    parameter int          EXT_AW   = 16,
    parameter int unsigned BASE     = 32'hC000,
    parameter int          WAIT_CYC = 2,
    parameter int          WORDS    = 512,
    localparam int         RAM_AW   = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ext_rd,
    output logic [EXT_AW-1:0] ext_addr,
    input  logic [7:0]        ext_data,
    input  logic              ext_flag,
    input  logic              host_wr,
    input  logic [1:0]        host_sel,
    input  logic [7:0]        host_data,
    input  logic              host_exit,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [23:0]       ram_wdata,
    output logic              busy,
    output logic              src_ext,
    output logic              done
);
    boot_state_t state_q;
    logic        rd_en, rd_clr, rd_byte_vld, rd_flag, rd_word_vld;
    word_t       rd_word, hp_word, acc_word;
    logic        hp_vld, acc, full;

    boot_ext_reader #(
        .EXT_AW(EXT_AW), .BASE(BASE), .WAIT_CYC(WAIT_CYC), .WORDS(WORDS)
    ) u_reader (
        .clk(clk), .rst_n(rst_n), .en(rd_en), .clr(rd_clr),
        .ext_rd(ext_rd), .ext_addr(ext_addr), .ext_data(ext_data),
        .ext_flag(ext_flag), .byte_vld(rd_byte_vld), .flag_bit(rd_flag),
        .word_vld(rd_word_vld), .word(rd_word)
    );

    boot_host_packer u_host (
        .clk(clk), .rst_n(rst_n), .wr(host_wr), .sel(host_sel),
        .data(host_data), .word_vld(hp_vld), .word(hp_word)
    );

    boot_ram_writer #(.WORDS(WORDS)) u_writer (
        .clk(clk), .rst_n(rst_n), .acc(acc), .word(acc_word),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .full(full)
    );

    // Sequencer: probe, load from the chosen source, pulse done, halt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PROBE;
            src_ext <= 1'b0;
        end else begin
            case (state_q)
                ST_PROBE: if (rd_byte_vld) begin
                    src_ext <= rd_flag;
                    state_q <= rd_flag ? ST_EXT : ST_HOST;
                end
                ST_EXT:   if (full) state_q <= ST_FIN;
                ST_HOST:  if (host_exit || full) state_q <= ST_FIN;
                ST_FIN:   state_q <= ST_HALT;
                default:  state_q <= ST_HALT;
            endcase
        end
    end

    // Reader control, word selection and status outputs
    always_comb begin
        rd_en    = (state_q == ST_PROBE) || (state_q == ST_EXT && !full);
        rd_clr   = (state_q == ST_PROBE) && rd_byte_vld;
        acc      = ((state_q == ST_EXT) && rd_word_vld) ||
                   ((state_q == ST_HOST) && hp_vld && !host_exit);
        acc_word = (state_q == ST_EXT) ? rd_word : hp_word;
        busy     = (state_q == ST_PROBE) || (state_q == ST_EXT) || (state_q == ST_HOST);
        done     = (state_q == ST_FIN);
    end

    // R8: done lasts exactly one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: the done cycle carries no RAM write
    a_r8_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ram_we);
    // R9: silence after completion
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> (!ram_we && !ext_rd));
    // R7: host exit finishes on the next cycle
    a_r7_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOST && host_exit) |=> done);
    // R2: host mode issues no external reads
    a_r2_host_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOST) |-> !ext_rd);
endmodule

// File: tb/boot_loader_bench.sv
`timescale 1ns/1ps
module boot_loader_bench;
    localparam int          N    = 16;
    localparam int          W    = 2;
    localparam int unsigned BASE = 32'hC000;
    localparam int          AW   = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_rd, ext_flag;
    logic [15:0]   ext_addr;
    logic [7:0]    ext_data;
    logic          host_wr = 1'b0, host_exit = 1'b0;
    logic [1:0]    host_sel = 2'd0;
    logic [7:0]    host_data = 8'd0;
    logic          ram_we, busy, src_ext, done;
    logic [AW-1:0] ram_addr;
    logic [23:0]   ram_wdata;
    logic          sel_flag = 1'b1;

    int checks = 0, failures = 0;
    int cyc = 0, wr_count = 0, done_count = 0, done_cycle = -1;
    int ext_cycles = 0, addr_err = 0, post_writes = 0, post_reads = 0;
    logic [23:0] rec [N];

    boot_loader #(.BASE(BASE), .WAIT_CYC(W), .WORDS(N)) u_boot_loader (
        .clk(clk), .rst_n(rst_n), .ext_rd(ext_rd), .ext_addr(ext_addr),
        .ext_data(ext_data), .ext_flag(ext_flag), .host_wr(host_wr),
        .host_sel(host_sel), .host_data(host_data), .host_exit(host_exit),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .busy(busy), .src_ext(src_ext), .done(done)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return (a[7:0] ^ 8'h5A) + a[15:8] + 8'(a[7:0] >> 3);
    endfunction
    function automatic logic [7:0] host_byte(input int n, input int k);
        return 8'(n * 37 + k * 91 + 5);
    endfunction

    // External memory model
    assign ext_data = mem_byte(ext_addr);
    assign ext_flag = (ext_addr == 16'(BASE)) ? sel_flag : ~sel_flag;

    // Cycle counter: posedges since reset release
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // Output monitor, sampled away from the active edge
    always @(negedge clk) if (rst_n) begin
        if (ext_rd) ext_cycles++;
        if (done_count > 0 && ext_rd) post_reads++;
        if (ram_we) begin
            if (done_count > 0) post_writes++;
            if (int'(ram_addr) != wr_count) addr_err++;
            rec[ram_addr] = ram_wdata;
            wr_count++;
        end
        if (done) begin
            done_count++;
            done_cycle = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start(input logic flag);
        @(posedge clk); #1;
        rst_n = 1'b0; sel_flag = flag;
        host_wr = 1'b0; host_exit = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        wr_count = 0; done_count = 0; done_cycle = -1; ext_cycles = 0;
        addr_err = 0; post_writes = 0; post_reads = 0;
        for (int i = 0; i < N; i++) rec[i] = '0;
        rst_n = 1'b1;
    endtask

    task automatic hwrite(input logic [1:0] s, input logic [7:0] d);
        @(posedge clk); #1;
        host_wr = 1'b1; host_sel = s; host_data = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic host_word(input int n);
        hwrite(2'd2, host_byte(n, 2));
        hwrite(2'd1, host_byte(n, 1));
        hwrite(2'd0, host_byte(n, 0));
    endtask

    initial begin
        #800000;
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // ---------- External path ----------
        start(1'b1);
        chk(busy && !done && !ram_we && !src_ext, "R1 reset outputs", {busy, done, ram_we, src_ext}, 4'b1000);
        chk(ext_rd && ext_addr == 16'(BASE), "R1 probe read", int'(ext_addr), int'(BASE));
        repeat ((3 * N + 1) * (W + 1) + 20) @(posedge clk);
        #1;
        chk(src_ext == 1'b1, "R2 external selected", int'(src_ext), 1);
        chk(wr_count == N, "R5 word count ext", wr_count, N);
        chk(addr_err == 0, "R5 address sequence ext", addr_err, 0);
        for (int n = 0; n < N; n++) begin
            logic [23:0] e;
            e = {mem_byte(16'(BASE + 3 * n + 2)), mem_byte(16'(BASE + 3 * n + 1)),
                 mem_byte(16'(BASE + 3 * n))};
            chk(rec[n] == e, "R3 ext word", int'(rec[n]), int'(e));
        end
        chk(ext_cycles == (3 * N + 1) * (W + 1), "R4 read cycles", ext_cycles, (3 * N + 1) * (W + 1));
        chk(done_cycle == (3 * N + 1) * (W + 1) + 1, "R4 done cycle", done_cycle, (3 * N + 1) * (W + 1) + 1);
        chk(done_count == 1, "R8 single done ext", done_count, 1);
        chk(!busy, "R8 busy low ext", int'(busy), 0);
        chk(post_writes == 0 && post_reads == 0, "R9 quiet after ext", post_writes + post_reads, 0);

        // ---------- Host path, full image ----------
        start(1'b0);
        repeat (8) @(posedge clk);
        for (int n = 0; n < N; n++) begin
            if (n % 3 == 1) begin
                hwrite(2'd1, host_byte(n, 1));
                hwrite(2'd3, 8'hEE);
                hwrite(2'd2, host_byte(n, 2));
                hwrite(2'd0, host_byte(n, 0));
            end else begin
                host_word(n);
            end
            if (n % 4 == 2) repeat (n % 5) @(posedge clk);
        end
        repeat (4) @(posedge clk);
        #1;
        chk(src_ext == 1'b0, "R2 host selected", int'(src_ext), 0);
        chk(ext_cycles == W + 1, "R2 only probe read", ext_cycles, W + 1);
        chk(wr_count == N, "R5 word count host", wr_count, N);
        chk(addr_err == 0, "R5 address sequence host", addr_err, 0);
        for (int n = 0; n < N; n++) begin
            logic [23:0] e;
            e = {host_byte(n, 2), host_byte(n, 1), host_byte(n, 0)};
            chk(rec[n] == e, "R6 host word", int'(rec[n]), int'(e));
        end
        chk(done_count == 1, "R8 single done host", done_count, 1);
        host_word(40);
        repeat (3) @(posedge clk);
        #1;
        chk(wr_count == N && post_writes == 0, "R9 host write ignored", wr_count, N);

        // ---------- Host path, early exit ----------
        start(1'b0);
        repeat (8) @(posedge clk);
        for (int n = 0; n < 5; n++) host_word(n + 7);
        hwrite(2'd2, 8'hA1);
        hwrite(2'd1, 8'hB2);
        begin
            int c0;
            @(posedge clk); #1;
            host_wr = 1'b1; host_sel = 2'd0; host_data = 8'hC3; host_exit = 1'b1;
            c0 = cyc;
            @(posedge clk); #1;
            host_wr = 1'b0; host_exit = 1'b0;
            repeat (3) @(posedge clk);
            #1;
            chk(done_cycle == c0 + 1, "R7 exit done timing", done_cycle, c0 + 1);
        end
        chk(wr_count == 5, "R7 colliding low write dropped", wr_count, 5);
        for (int n = 0; n < 5; n++) begin
            logic [23:0] e;
            e = {host_byte(n + 7, 2), host_byte(n + 7, 1), host_byte(n + 7, 0)};
            chk(rec[n] == e, "R7 words before exit", int'(rec[n]), int'(e));
        end
        chk(done_count == 1 && !busy, "R8 done after exit", done_count, 1);
        host_word(3);
        repeat (3) @(posedge clk);
        #1;
        chk(wr_count == 5 && post_writes == 0, "R9 ignored after exit", wr_count, 5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule